// File: doc/BRIEF.md
# Interrupt Pin Servicing Engine

This block sits between a set of interrupt input wires and the message path toward the processors. Each pin has a configuration entry supplied from outside: mask, trigger mode (edge or level), vector, delivery mode, destination mode and a 16-bit destination field. The block samples the inputs once per clock and keeps one pending bit per pin. It chooses the lowest-numbered pin that is ready to go and emits a single address/data message for it over a valid/ready handshake.

Level-triggered pins use a remote-pending flag. Once a level interrupt has been sent, that pin cannot be sent again until an end-of-interrupt pulse arrives with the pin's vector. If the input is still high and the pin is unmasked at that point, the interrupt goes out again. Edge-triggered pins are sent once per rising transition, and a rising transition that arrives while the pin is masked is thrown away. Input 0 is wired to pin 2.

Top module: `irq_svc_engine`

## Requirements
- R1: After reset, msg_valid is 0 and every remote_pend bit is 0.
- R2: A rising transition on an unmasked edge-mode pin produces exactly one message. Holding the input high afterwards produces no further message.
- R3: A rising transition on an edge-mode pin that is masked at that moment is discarded. Unmasking the pin later does not deliver it.
- R4: On a level-mode pin, a high unmasked input delivers one message and sets that pin's remote_pend bit. While that bit stays set, no further message is sent for the pin.
- R5: On a level-mode pin, the pending bit follows the input. A level that went high and then low while masked is not delivered on unmask. A level that is still high when unmasked is delivered.
- R6: An end-of-interrupt pulse with vector V clears remote_pend on every pin whose vector equals V. If that pin's input is still high and the pin is unmasked, the message is sent again. A pulse with a different vector changes nothing.
- R7: Input 0 drives pin 2, so its message carries pin 2's entry. Pin 0 never delivers.
- R8: When several pins are ready at once, messages leave in ascending pin order.
- R9: While msg_valid is high and msg_ready is low, the message address and data stay unchanged. Input events that arrive during the stall are still recorded and delivered afterwards.
- R10: msg_addr = 0xFEE00000 with the destination in bits 19:4 and the destination-mode bit in bit 2. msg_data holds the vector in bits 7:0, the delivery mode in bits 10:8 and the trigger mode in bit 15 (1 = level). All other bits are 0.
- R11: Configuring a pin as edge-mode clears its remote_pend bit.
- R12: With the slot empty, msg_valid rises on the second rising clock edge after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_PINS | Interrupt input levels |
| cfg_mask | input | NUM_PINS | Per-pin mask, 1 = masked |
| cfg_level | input | NUM_PINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NUM_PINS*8 | Per-pin vector, pin p at bits [8p+7:8p] |
| cfg_dlv | input | NUM_PINS*3 | Per-pin delivery mode, pin p at bits [3p+2:3p] |
| cfg_dmode | input | NUM_PINS | Per-pin destination mode bit |
| cfg_dest | input | NUM_PINS*16 | Per-pin destination field, pin p at bits [16p+15:16p] |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt pulse |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_valid | output | 1 | A message is being offered |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| remote_pend | output | NUM_PINS | Per-pin remote-pending flags |

## Verification
A stuck remote-pending flag shows at the ports as a level pin that stays silent after a matching end-of-interrupt. A flag lost too early shows as a repeated message within three cycles of the first one being accepted. A pending bit corrupted by a masked or already-served event appears as an unexpected message two edges later, or as a missing one. Selection order and stall handling are visible in the order of messages and in whether the offered message stays stable while ready is low.

// File: rtl/irq_svc_pkg.sv
// Package: shared constants and message packing helpers for the
// interrupt servicing engine. Field widths here are fixed by the
// message format; the pin count is a parameter of the top.
package irq_svc_pkg;

    localparam int VEC_W  = 8;
    localparam int DLV_W  = 3;
    localparam int DEST_W = 16;

    localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;

    // Build the message address from destination and destination mode.
    function automatic logic [31:0] pack_addr(input logic [DEST_W-1:0] dest,
                                              input logic dmode);
        return MSG_BASE | {12'd0, dest, 4'd0} | {29'd0, dmode, 2'd0};
    endfunction

    // Build the message data word from vector, delivery mode and trigger.
    function automatic logic [31:0] pack_data(input logic [VEC_W-1:0] vec,
                                              input logic [DLV_W-1:0] dlv,
                                              input logic trig);
        return {16'd0, trig, 4'd0, dlv, vec};
    endfunction

endpackage

// File: rtl/irq_in_stage.sv
// Input stage: routes the input wires onto pins (one input is aliased
// onto another pin), detects rising transitions against the previous
// sample and holds the per-pin pending bits.
// Assumes: inputs are already synchronous to clk; clr_pend only marks
// edge-mode pins that were just loaded into the message slot.
module irq_in_stage #(
    parameter int NUM_PINS  = 24,
    parameter int REMAP_SRC = 0,
    parameter int REMAP_DST = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_in,
    input  logic [NUM_PINS-1:0] cfg_mask,
    input  logic [NUM_PINS-1:0] cfg_level,
    input  logic [NUM_PINS-1:0] clr_pend,
    output logic [NUM_PINS-1:0] pend
);

    logic [NUM_PINS-1:0] src;
    logic [NUM_PINS-1:0] src_q;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] pend_nxt;

    // Map input wires onto pins, with the aliased input folded in.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
        if (p == REMAP_DST) begin : g_dst
            assign src[p] = irq_in[p] | irq_in[REMAP_SRC];
        end else if (p == REMAP_SRC) begin : g_src
            assign src[p] = 1'b0;
        end else begin : g_plain
            assign src[p] = irq_in[p];
        end
    end

    // Rising transitions relative to the previous sample.
    assign rise = src & ~src_q;

    // Next pending: level pins track input, edge pins latch unmasked rises.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            if (cfg_level[p]) begin
                pend_nxt[p] = src[p];
            end else begin
                pend_nxt[p] = (pend[p] & ~clr_pend[p]) | (rise[p] & ~cfg_mask[p]);
            end
        end
    end

    // Register the previous sample and the pending vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            pend  <= '0;
        end else begin
            src_q <= src;
            pend  <= pend_nxt;
        end
    end

    // R3
    masked_edge_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(cfg_level)) & $past(cfg_mask)) == '0);

endmodule

// File: rtl/irq_remote_track.sv
// Remote-pending tracker: one flag per pin. A flag is set when a level
// interrupt is loaded for delivery, cleared by an end-of-interrupt that
// carries the pin's vector, and forced clear while the pin is edge-mode.
// Assumes: set_rp marks only level-mode pins.
module irq_remote_track #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       cfg_level,
    input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    input  logic [NUM_PINS-1:0]       set_rp,
    output logic [NUM_PINS-1:0]       rpend
);

    logic [NUM_PINS-1:0] eoi_hit;

    // Per-pin vector compare against the end-of-interrupt vector.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_match
        assign eoi_hit[p] = eoi_valid & rpend[p] &
                            (cfg_vector[p*VEC_W +: VEC_W] == eoi_vector);
    end

    // Update flags: a fresh delivery wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpend <= '0;
        end else begin
            rpend <= ((rpend & ~eoi_hit) | set_rp) & cfg_level;
        end
    end

    // R11
    rpend_edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpend & ~$past(cfg_level)) == '0);

endmodule

// File: rtl/irq_pick.sv
// Picker: finds the lowest-numbered pin that is pending, unmasked and
// not blocked by its remote-pending flag, and loads its message into a
// one-deep output slot when the slot is free or being drained.
// Assumes: the downstream follows valid/ready; the slot holds while stalled.
module irq_pick #(
    parameter int NUM_PINS = 24
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [NUM_PINS-1:0]                      pend,
    input  logic [NUM_PINS-1:0]                      cfg_mask,
    input  logic [NUM_PINS-1:0]                      cfg_level,
    input  logic [NUM_PINS-1:0]                      rpend,
    input  logic [NUM_PINS*irq_svc_pkg::VEC_W-1:0]   cfg_vector,
    input  logic [NUM_PINS*irq_svc_pkg::DLV_W-1:0]   cfg_dlv,
    input  logic [NUM_PINS-1:0]                      cfg_dmode,
    input  logic [NUM_PINS*irq_svc_pkg::DEST_W-1:0]  cfg_dest,
    input  logic                                     msg_ready,
    output logic                                     msg_valid,
    output logic [31:0]                              msg_addr,
    output logic [31:0]                              msg_data,
    output logic [NUM_PINS-1:0]                      grant,
    output logic                                     load_fire
);
    import irq_svc_pkg::*;

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] elig;
    logic [IDX_W-1:0]    sel;
    logic                found;
    logic                slot_free;

    // Pins allowed to deliver this cycle.
    assign elig = pend & ~cfg_mask & ~(cfg_level & rpend);

    // Lowest eligible index wins.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign slot_free = !msg_valid || msg_ready;
    assign load_fire = slot_free && found;

    // One-hot grant of the pin being loaded.
    always_comb begin
        grant = '0;
        if (load_fire) begin
            grant[sel] = 1'b1;
        end
    end

    // Output slot: load on grant, drop on acceptance, hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_addr  <= '0;
            msg_data  <= '0;
        end else if (load_fire) begin
            msg_valid <= 1'b1;
            msg_addr  <= pack_addr(cfg_dest[int'(sel)*DEST_W +: DEST_W], cfg_dmode[sel]);
            msg_data  <= pack_data(cfg_vector[int'(sel)*VEC_W +: VEC_W],
                                   cfg_dlv[int'(sel)*DLV_W +: DLV_W], cfg_level[sel]);
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // R9
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

endmodule

// File: rtl/irq_svc_engine.sv
// Top: interrupt servicing engine. Joins the input stage, the
// remote-pending tracker and the picker. A loaded edge pin clears its
// pending bit; a loaded level pin raises its remote-pending flag.
// Assumes: NUM_PINS > REMAP_DST and REMAP_SRC; entries are stable
// enough that a change takes effect on the next edge.
module irq_svc_engine #(
    parameter int NUM_PINS  = 24,
    parameter int REMAP_SRC = 0,
    parameter int REMAP_DST = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [NUM_PINS-1:0]                      irq_in,
    input  logic [NUM_PINS-1:0]                      cfg_mask,
    input  logic [NUM_PINS-1:0]                      cfg_level,
    input  logic [NUM_PINS*irq_svc_pkg::VEC_W-1:0]   cfg_vector,
    input  logic [NUM_PINS*irq_svc_pkg::DLV_W-1:0]   cfg_dlv,
    input  logic [NUM_PINS-1:0]                      cfg_dmode,
    input  logic [NUM_PINS*irq_svc_pkg::DEST_W-1:0]  cfg_dest,
    input  logic                                     eoi_valid,
    input  logic [irq_svc_pkg::VEC_W-1:0]            eoi_vector,
    input  logic                                     msg_ready,
    output logic                                     msg_valid,
    output logic [31:0]                              msg_addr,
    output logic [31:0]                              msg_data,
    output logic [NUM_PINS-1:0]                      remote_pend
);
    import irq_svc_pkg::*;

    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] grant;
    logic                load_fire;
    logic [NUM_PINS-1:0] clr_pend;
    logic [NUM_PINS-1:0] set_rp;

    // Split the grant by trigger mode.
    assign clr_pend = grant & ~cfg_level;
    assign set_rp   = grant & cfg_level;

    irq_in_stage #(
        .NUM_PINS  (NUM_PINS),
        .REMAP_SRC (REMAP_SRC),
        .REMAP_DST (REMAP_DST)
    ) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .cfg_mask  (cfg_mask),
        .cfg_level (cfg_level),
        .clr_pend  (clr_pend),
        .pend      (pend)
    );

    irq_remote_track #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W)
    ) u_rp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_level  (cfg_level),
        .cfg_vector (cfg_vector),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .set_rp     (set_rp),
        .rpend      (remote_pend)
    );

    irq_pick #(
        .NUM_PINS (NUM_PINS)
    ) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .cfg_mask   (cfg_mask),
        .cfg_level  (cfg_level),
        .rpend      (remote_pend),
        .cfg_vector (cfg_vector),
        .cfg_dlv    (cfg_dlv),
        .cfg_dmode  (cfg_dmode),
        .cfg_dest   (cfg_dest),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_addr   (msg_addr),
        .msg_data   (msg_data),
        .grant      (grant),
        .load_fire  (load_fire)
    );

    // R4
    rp_set_after_level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && |(grant & cfg_level)) |=> |(remote_pend & $past(grant)));

    // R4
    rp_rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(remote_pend & ~$past(remote_pend)) |-> $past(load_fire));

    // R2
    load_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> msg_valid);

endmodule

// File: tb/tb_irq_svc_engine.sv
module tb_irq_svc_engine;

    localparam int N = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  cfg_mask = '1;
    logic [N-1:0]  cfg_level = '0;
    logic [N*8-1:0]  cfg_vector = '0;
    logic [N*3-1:0]  cfg_dlv = '0;
    logic [N-1:0]  cfg_dmode = '0;
    logic [N*16-1:0] cfg_dest = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_ready = 1'b1;
    logic          msg_valid;
    logic [31:0]   msg_addr;
    logic [31:0]   msg_data;
    logic [N-1:0]  remote_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_svc_engine #(.NUM_PINS(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_mask(cfg_mask),
        .cfg_level(cfg_level), .cfg_vector(cfg_vector), .cfg_dlv(cfg_dlv),
        .cfg_dmode(cfg_dmode), .cfg_dest(cfg_dest), .eoi_valid(eoi_valid),
        .eoi_vector(eoi_vector), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data), .remote_pend(remote_pend)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic set_entry(input int p, input bit m, input bit lvl, input logic [7:0] v,
                             input logic [2:0] d, input bit dm, input logic [15:0] ds);
        cfg_mask[p] = m;
        cfg_level[p] = lvl;
        cfg_vector[p*8 +: 8] = v;
        cfg_dlv[p*3 +: 3] = d;
        cfg_dmode[p] = dm;
        cfg_dest[p*16 +: 16] = ds;
    endtask

    // Poll up to 8 cycles for a message, then compare it.
    task automatic wait_msg(input logic [31:0] ea, input logic [31:0] ed, input string req);
        int n = 0;
        while (!msg_valid && n < 8) begin
            @(negedge clk);
            n++;
        end
        check(msg_valid, req, 32'(msg_valid), 32'd1);
        check(msg_addr == ea, req, msg_addr, ea);
        check(msg_data == ed, req, msg_data, ed);
        @(negedge clk);
    endtask

    task automatic expect_quiet(input int cyc, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, req, 32'(seen), 32'd0);
    endtask

    task automatic pulse_eoi(input logic [7:0] v);
        eoi_vector = v;
        eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    // R1: reset state
    task automatic t_reset();
        check(!msg_valid, "R1", 32'(msg_valid), 32'd0);
        check(remote_pend == '0, "R1", 32'(remote_pend), 32'd0);
    endtask

    // R2, R10, R12: edge delivery, format and latency
    task automatic t_edge();
        set_entry(5, 0, 0, 8'h35, 3'd0, 1, 16'h1234);
        @(negedge clk);
        irq_in[5] = 1'b1;
        @(negedge clk);
        check(!msg_valid, "R12", 32'(msg_valid), 32'd0);
        @(negedge clk);
        check(msg_valid, "R12", 32'(msg_valid), 32'd1);
        check(msg_addr == 32'hFEE1_2344, "R10", msg_addr, 32'hFEE1_2344);
        check(msg_data == 32'h0000_0035, "R2", msg_data, 32'h0000_0035);
        expect_quiet(6, "R2");
        irq_in[5] = 1'b0;
        @(negedge clk);
    endtask

    // R3: masked edge discarded
    task automatic t_masked_edge();
        set_entry(6, 1, 0, 8'h36, 3'd0, 0, 16'h0);
        @(negedge clk);
        irq_in[6] = 1'b1;
        @(negedge clk);
        irq_in[6] = 1'b0;
        @(negedge clk);
        cfg_mask[6] = 1'b0;
        expect_quiet(6, "R3");
    endtask

    // R4, R6, R10: level delivery with remote-pending and end-of-interrupt
    task automatic t_level();
        set_entry(9, 0, 1, 8'h49, 3'd1, 0, 16'h00AB);
        @(negedge clk);
        irq_in[9] = 1'b1;
        wait_msg(32'hFEE0_0AB0, 32'h0000_8149, "R4");
        check(remote_pend[9], "R4", 32'(remote_pend), 32'h200);
        expect_quiet(6, "R4");
        pulse_eoi(8'h48);
        expect_quiet(5, "R6");
        check(remote_pend[9], "R6", 32'(remote_pend), 32'h200);
        pulse_eoi(8'h49);
        wait_msg(32'hFEE0_0AB0, 32'h0000_8149, "R6");
        irq_in[9] = 1'b0;
        @(negedge clk);
        pulse_eoi(8'h49);
        @(negedge clk);
        check(!remote_pend[9], "R6", 32'(remote_pend[9]), 32'd0);
        expect_quiet(5, "R5");
    endtask

    // R7: input 0 routed to pin 2
    task automatic t_remap();
        set_entry(0, 0, 0, 8'h20, 3'd0, 0, 16'h0);
        set_entry(2, 0, 0, 8'h22, 3'd0, 0, 16'h0);
        @(negedge clk);
        irq_in[0] = 1'b1;
        wait_msg(32'hFEE0_0000, 32'h0000_0022, "R7");
        expect_quiet(5, "R7");
        irq_in[0] = 1'b0;
        @(negedge clk);
    endtask

    // R8, R9: ascending order under a stalled slot
    task automatic t_order();
        set_entry(3, 0, 0, 8'h33, 3'd0, 0, 16'h0);
        set_entry(7, 0, 0, 8'h37, 3'd0, 0, 16'h0);
        msg_ready = 1'b0;
        @(negedge clk);
        irq_in[3] = 1'b1;
        irq_in[7] = 1'b1;
        repeat (3) @(negedge clk);
        check(msg_valid && msg_data == 32'h33, "R8", msg_data, 32'h33);
        repeat (4) @(negedge clk);
        check(msg_valid && msg_data == 32'h33, "R9", msg_data, 32'h33);
        msg_ready = 1'b1;
        @(negedge clk);
        check(msg_valid && msg_data == 32'h37, "R9", msg_data, 32'h37);
        @(negedge clk);
        irq_in[3] = 1'b0;
        irq_in[7] = 1'b0;
        expect_quiet(4, "R8");
    endtask

    // R5: level pending follows the input while masked
    task automatic t_level_masked();
        set_entry(14, 1, 1, 8'h5E, 3'd0, 0, 16'h0);
        @(negedge clk);
        irq_in[14] = 1'b1;
        repeat (2) @(negedge clk);
        irq_in[14] = 1'b0;
        repeat (2) @(negedge clk);
        cfg_mask[14] = 1'b0;
        expect_quiet(6, "R5");
        irq_in[14] = 1'b1;
        cfg_mask[14] = 1'b1;
        repeat (3) @(negedge clk);
        cfg_mask[14] = 1'b0;
        wait_msg(32'hFEE0_0000, 32'h0000_805E, "R5");
        irq_in[14] = 1'b0;
        @(negedge clk);
        pulse_eoi(8'h5E);
    endtask

    // R11: switching to edge mode clears remote-pending
    task automatic t_edge_clears();
        set_entry(12, 0, 1, 8'h5C, 3'd2, 0, 16'h0);
        @(negedge clk);
        irq_in[12] = 1'b1;
        wait_msg(32'hFEE0_0000, 32'h0000_825C, "R11");
        check(remote_pend[12], "R11", 32'(remote_pend[12]), 32'd1);
        irq_in[12] = 1'b0;
        cfg_level[12] = 1'b0;
        repeat (2) @(negedge clk);
        check(!remote_pend[12], "R11", 32'(remote_pend[12]), 32'd0);
        cfg_level[12] = 1'b1;
        @(negedge clk);
        irq_in[12] = 1'b1;
        wait_msg(32'hFEE0_0000, 32'h0000_825C, "R11");
        irq_in[12] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_masked_edge();
        t_level();
        t_remap();
        t_order();
        t_level_masked();
        t_edge_clears();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule